// File: doc/BRIEF.md
# Multi-Channel Pattern Trigger

This block watches a bus of sampled digital channels and produces a one-cycle trigger pulse once the channels meet a per-channel condition. Each channel is given a 3-bit condition code. A code can make the channel don't-care, require a level (low or high), or look for a transition (rising, falling or either). Channels with a level code must all hold their level at once. Channels with an edge code are combined by OR, so any single one of their edges is enough. The trigger fires only when the level part and the edge part are both satisfied.

Codes are written one channel at a time into a staging store. Arming the block copies the staging store into the active pattern. While the block is armed, each valid sample is registered and compared with the previous valid sample to find edges. After a trigger the block disarms, unless continuous mode is selected, in which case every later matching sample fires again. The channel count is a parameter. The default of 42 covers 34 analyzer inputs plus 8 general digital lines.

Top module: `pattern_trig`

## Requirements
- R1: Condition codes are 3'b000 don't-care, 3'b001 low, 3'b010 high, 3'b011 rising, 3'b100 falling and 3'b101 either edge. Codes 3'b110 and 3'b111 behave as don't-care. A don't-care channel affects neither the level part nor the edge part.
- R2: The level part is true only when every channel coded low reads 0 and every channel coded high reads 1 in the current sample.
- R3: The edge part is true when at least one edge-coded channel shows its edge between the previous and the current valid sample. Rising means 0 to 1, falling means 1 to 0, and either accepts both.
- R4: A match needs the level part and the edge part to be true on the same sample.
- R5: With no edge-coded channel the edge part counts as true. With no level-coded channel the level part counts as true.
- R6: Edge conditions cannot match on the first valid sample after reset or after an arm, because no reference sample exists yet. Level-only patterns can still match on that sample.
- R7: trig_out is high for exactly one cycle per matching sample. It rises on the second rising clock edge after the sample is presented with sample_valid high.
- R8: After a trigger with continuous low, armed_out drops on the same edge and no further trigger occurs until the next arm. With continuous high the block stays armed.
- R9: Code writes go to the staging store only. The active pattern changes only when arm is pulsed, so a write made while armed has no effect until the next arm.
- R10: After reset, trig_out and armed_out are 0 and every code is don't-care. No trigger is produced while disarmed or in the cycle in which arm is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | sample_in carries a new sample this cycle |
| sample_in | input | N | Channel sample bus |
| cfg_we | input | 1 | Write one condition code into the staging store |
| cfg_addr | input | $clog2(N) | Channel index for the write; indexes of N or more are ignored |
| cfg_code | input | 3 | Condition code to write |
| arm | input | 1 | Pulse: load the staging store into the active pattern and arm |
| continuous | input | 1 | 1 keeps the block armed after a trigger |
| trig_out | output | 1 | One-cycle trigger pulse |
| armed_out | output | 1 | Block is armed |

## Verification
The checker watches the timing and control rules on every cycle. A pulse on trig_out must trace back to a valid sample two cycles earlier, to an armed block, and to a cycle without an arm pulse. armed_out may only rise after an arm pulse, and it must drop with a trigger when continuous mode is off. The pattern logic itself can only be shown by the bench's sample sequences: the AND of level conditions, the OR of edge conditions, ignored and unused codes, the blocked first edge, the pure-level and pure-edge defaults, and staged writes taking effect only at the next arm.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [2:0] {
    COND_ANY  = 3'b000,
    COND_LOW  = 3'b001,
    COND_HIGH = 3'b010,
    COND_RISE = 3'b011,
    COND_FALL = 3'b100,
    COND_BOTH = 3'b101
  } cond_t;
  localparam int COND_W = 3;
endpackage

// File: rtl/pt_sample_reg.sv
module pt_sample_reg #(
  parameter int N = 42
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         valid,
  input  logic [N-1:0] din,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev,
  output logic         cur_valid,
  output logic         ref_ok
);
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= '0;
      prev      <= '0;
      cur_valid <= 1'b0;
      ref_ok    <= 1'b0;
      seen      <= 1'b0;
    end else begin
      cur_valid <= valid;
      if (valid) begin
        cur    <= din;
        prev   <= cur;
        ref_ok <= seen && !restart;
        seen   <= 1'b1;
      end else if (restart) begin
        seen   <= 1'b0;
        ref_ok <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pt_cond_eval.sv
module pt_cond_eval
  import pt_pkg::*;
#(
  parameter int N = 42
) (
  input  logic [N*COND_W-1:0] codes,
  input  logic [N-1:0]        cur,
  input  logic [N-1:0]        prev,
  input  logic                ref_ok,
  output logic                hit
);
  logic [N-1:0] lvl_ok;
  logic [N-1:0] is_edge;
  logic [N-1:0] edge_seen;

  for (genvar i = 0; i < N; i++) begin : g_chan
    logic [COND_W-1:0] c;
    logic rise, fall;
    assign c    = codes[i*COND_W +: COND_W];
    assign rise = cur[i] && !prev[i];
    assign fall = !cur[i] && prev[i];
    always_comb begin
      lvl_ok[i]    = 1'b1;
      is_edge[i]   = 1'b0;
      edge_seen[i] = 1'b0;
      case (c)
        COND_LOW:  lvl_ok[i] = !cur[i];
        COND_HIGH: lvl_ok[i] = cur[i];
        COND_RISE: begin is_edge[i] = 1'b1; edge_seen[i] = rise; end
        COND_FALL: begin is_edge[i] = 1'b1; edge_seen[i] = fall; end
        COND_BOTH: begin is_edge[i] = 1'b1; edge_seen[i] = rise || fall; end
        default: ;
      endcase
    end
  end

  logic level_term, edge_term;
  assign level_term = &lvl_ok;
  assign edge_term  = !(|is_edge) || (ref_ok && (|edge_seen));
  assign hit        = level_term && edge_term;
endmodule

// File: rtl/pt_arm_ctrl.sv
module pt_arm_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic continuous,
  input  logic cur_valid,
  input  logic hit,
  output logic armed,
  output logic trig
);
  logic fire;
  assign fire = armed && !arm && cur_valid && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      trig  <= 1'b0;
    end else begin
      trig <= fire;
      if (arm)                      armed <= 1'b1;
      else if (fire && !continuous) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/pattern_trig.sv
module pattern_trig
  import pt_pkg::*;
#(
  parameter  int N  = 42,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_valid,
  input  logic [N-1:0]  sample_in,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [2:0]    cfg_code,
  input  logic          arm,
  input  logic          continuous,
  output logic          trig_out,
  output logic          armed_out
);
  localparam int PW = N * COND_W;

  logic [PW-1:0] staged;
  logic [PW-1:0] active;

  for (genvar i = 0; i < N; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)                                    staged[i*COND_W +: COND_W] <= COND_ANY;
      else if (cfg_we && cfg_addr == AW'(i))      staged[i*COND_W +: COND_W] <= cfg_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      active <= '0;
    else if (arm) active <= staged;
  end

  logic [N-1:0] cur, prev;
  logic cur_valid, ref_ok, hit;

  pt_sample_reg #(.N(N)) u_samp (
    .clk(clk), .rst(rst), .restart(arm), .valid(sample_valid), .din(sample_in),
    .cur(cur), .prev(prev), .cur_valid(cur_valid), .ref_ok(ref_ok)
  );

  pt_cond_eval #(.N(N)) u_eval (
    .codes(active), .cur(cur), .prev(prev), .ref_ok(ref_ok), .hit(hit)
  );

  pt_arm_ctrl u_ctrl (
    .clk(clk), .rst(rst), .arm(arm), .continuous(continuous),
    .cur_valid(cur_valid), .hit(hit), .armed(armed_out), .trig(trig_out)
  );
endmodule

// File: rtl/pt_checker.sv
module pt_checker (
  input logic clk,
  input logic rst,
  input logic sample_valid,
  input logic arm,
  input logic continuous,
  input logic trig_out,
  input logic armed_out
);
  a_r7_from_sample: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> $past(sample_valid, 2));
  a_r10_needs_armed: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> $past(armed_out));
  a_r10_not_on_arm: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> !$past(arm));
  a_r8_single_disarms: assert property (@(posedge clk) disable iff (rst)
    (trig_out && !$past(continuous)) |-> !armed_out);
  a_r8_cont_stays: assert property (@(posedge clk) disable iff (rst)
    (trig_out && $past(continuous)) |-> armed_out);
  a_r9_arm_only_by_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_out) |-> $past(arm));
endmodule

bind pattern_trig pt_checker u_chk (
  .clk(clk), .rst(rst), .sample_valid(sample_valid), .arm(arm),
  .continuous(continuous), .trig_out(trig_out), .armed_out(armed_out)
);

// File: tb/pattern_trig_test.sv
`timescale 1ns/1ps
module pattern_trig_test;
  localparam int N  = 42;
  localparam int AW = $clog2(N);

  logic clk = 0, rst = 1, sample_valid = 0, cfg_we = 0, arm = 0, continuous = 0;
  logic [N-1:0]  sample_in = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic [2:0]    cfg_code = '0;
  logic trig_out, armed_out;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pattern_trig #(.N(N)) uut (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_in(sample_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_code(cfg_code), .arm(arm),
    .continuous(continuous), .trig_out(trig_out), .armed_out(armed_out)
  );

  // {D7..D0 sample, expected trigger} for pattern D7=rise D6=fall D5=any D4..D2=high D1..D0=low
  localparam logic [8:0] VEC [13] = '{
    {8'b0001_1100, 1'b0},  // R6 first sample: edge blocked
    {8'b1001_1100, 1'b1},  // R3 D7 rises
    {8'b1001_1100, 1'b0},  // R4 no edge
    {8'b1101_1100, 1'b0},  // R3 D6 rises, wrong direction
    {8'b1001_1100, 1'b1},  // R3 D6 falls
    {8'b0011_1100, 1'b0},  // R3 D7 falls, wrong direction
    {8'b1011_1100, 1'b1},  // R1 D5 ignored, D7 rises
    {8'b0101_1100, 1'b0},  // R3 wrong directions on both
    {8'b1001_1101, 1'b0},  // R2 D0 high breaks level part
    {8'b0101_1100, 1'b0},
    {8'b1101_0100, 1'b0},  // R2 D3 low breaks level part
    {8'b0101_1100, 1'b0},
    {8'b1001_1100, 1'b1}   // R4 both edges with levels met
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [2:0] code);
    @(negedge clk); cfg_we = 1; cfg_addr = AW'(ch); cfg_code = code;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
  endtask

  task automatic apply(input logic [N-1:0] s, input logic exp, input string tag);
    sample_in = s; sample_valid = 1;
    @(negedge clk); sample_valid = 0;
    @(negedge clk); chk(trig_out, exp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(trig_out, 1'b0, "R10 reset trig");
    chk(armed_out, 1'b0, "R10 reset armed");

    // R10: disarmed, all-ignore pattern would match but must not fire
    apply('0, 1'b0, "R10 disarmed no trigger");

    // R5 level-only (all don't-care) fires on first sample; R8 single-shot disarms
    do_arm();
    chk(armed_out, 1'b1, "R8 armed after arm");
    apply('0, 1'b1, "R5 empty pattern fires on first sample");
    chk(armed_out, 1'b0, "R8 disarm after trigger");
    @(negedge clk);
    chk(trig_out, 1'b0, "R7 pulse is one cycle");
    apply('0, 1'b0, "R8 no trigger after disarm");

    // R9: write while armed has no effect until re-arm
    do_arm();
    wr(0, 3'b010);
    apply('0, 1'b1, "R9 staged write not yet active");
    do_arm();
    apply('0, 1'b0, "R9 new code active after arm (ch0 low)");
    apply(N'(1), 1'b1, "R9 ch0 high matches");

    // Example pattern table, continuous mode
    wr(0, 3'b001); wr(1, 3'b001); wr(2, 3'b010); wr(3, 3'b010); wr(4, 3'b010);
    wr(5, 3'b000); wr(6, 3'b100); wr(7, 3'b011);
    continuous = 1;
    do_arm();
    for (int k = 0; k < 13; k++) begin
      apply(N'(VEC[k][8:1]), VEC[k][0], $sformatf("R3/R4 table vector %0d", k));
    end
    chk(armed_out, 1'b1, "R8 continuous stays armed");

    // R3 either edge, R5 no level channels, R1 unused code ignored
    for (int ch = 0; ch < 8; ch++) wr(ch, 3'b000);
    wr(9, 3'b101);
    wr(10, 3'b110);
    do_arm();
    apply(N'(1) << 9, 1'b0, "R6 edge blocked on first sample after arm");
    apply('0, 1'b1, "R3 either edge: falling");
    apply(N'(1) << 10, 1'b0, "R1 unused code 110 ignored");
    apply(N'(1) << 9, 1'b1, "R3 either edge: rising, R5 no level channels");
    apply(N'(1) << 9, 1'b0, "R3 no edge no trigger");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule